// File: doc/BRIEF.md
# Accumulator Machine Register-Transfer Datapath

This block is the register file and datapath of a small accumulator machine. A separate sequencer drives it with one strobe per register transfer. It holds a program counter, a memory address register, a memory buffer register, an instruction register and an accumulator, together with an arithmetic unit that adds or multiplies. It makes no decisions of its own. Each rising clock edge applies the transfers whose strobes are high.

Memory is byte addressed, with a 32-bit address and 16-bit words. Every instruction is one word long, so each program-counter step adds two. The sequencer builds an instruction fetch from three transfers: the address from the PC, the read into the buffer while the PC steps, and the copy into the instruction register. It builds the operand phases of load, store, add and multiply from the same kind of strobes. The operand address is the low 14 bits of the instruction, zero-extended.

Top module: `acc_datapath`

## Requirements
- R1: When `rst` is high at a rising edge, the PC, accumulator, instruction register, address register (`mem_addr`) and buffer register (`mem_wdata`) all read zero after that edge.
- R2: With `pc_step` high, the PC becomes its previous value plus 2 at the edge. With `pc_step` low, the PC keeps its value.
- R3: `ld_mar_pc` loads the address register from the PC. If `ld_mar_ir` is also high, `ld_mar_pc` wins.
- R4: When only `ld_mar_ir` is high, the address register takes instruction bits [13:0] in its low bits and zeros in bits [31:14].
- R5: `ld_mbr_mem` loads the buffer register from `mem_rdata` and wins over `ld_mbr_ac`. In the same cycle, `mem_rd_req` equals `ld_mbr_mem`.
- R6: When only `ld_mbr_ac` is high, the buffer register takes the accumulator value.
- R7: `ld_ir` loads the instruction register from the buffer register.
- R8: `ld_ac_mbr` loads the accumulator directly from the buffer register and wins over `ld_ac_alu`.
- R9: When only `ld_ac_alu` is high, the accumulator takes the arithmetic result. With `alu_mul`=0 the result is (AC+MBR) mod 2^16. With `alu_mul`=1 it is the low 16 bits of AC×MBR. No carry is kept.
- R10: `mem_addr` always shows the address register and `mem_wdata` always shows the buffer register. `mem_wr_req` equals `wr_strobe` in the same cycle.
- R11: A register whose load strobes are all low keeps its value across the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_mar_pc | input | 1 | Address register takes the PC |
| ld_mar_ir | input | 1 | Address register takes the instruction's address field |
| ld_mbr_mem | input | 1 | Buffer register takes the read data; also raises the read request |
| ld_mbr_ac | input | 1 | Buffer register takes the accumulator |
| pc_step | input | 1 | PC advances by one instruction (2 bytes) |
| ld_ir | input | 1 | Instruction register takes the buffer register |
| ld_ac_mbr | input | 1 | Accumulator takes the buffer register |
| ld_ac_alu | input | 1 | Accumulator takes the arithmetic result |
| alu_mul | input | 1 | 0 selects add, 1 selects multiply |
| wr_strobe | input | 1 | Memory write request |
| mem_rdata | input | 16 | Memory read data, valid in the cycle the read is requested |
| mem_addr | output | 32 | Byte address (address register) |
| mem_wdata | output | 16 | Write data (buffer register) |
| mem_rd_req | output | 1 | Read request |
| mem_wr_req | output | 1 | Write request |
| pc | output | 32 | Program counter |
| ac | output | 16 | Accumulator |
| ir | output | 16 | Instruction register |

## Verification
The assertions take for granted that every strobe is a known 0 or 1 at each edge. They also assume that `mem_rdata` carries a known value whenever `ld_mbr_mem` is high, because the buffer check compares against the sampled read data. The bench meets both conditions. It clears all strobes at each falling edge, and it drives `mem_rdata` from either a preset reply register or a fully initialised word array. Simultaneous strobes aimed at one register are applied only in the priority tests, and the assertions are written to the priority order so that these tests stay within what they expect.

// File: rtl/acc_dp_pkg.sv
package acc_dp_pkg;
  localparam int unsigned ADDR_W_DEF  = 32;
  localparam int unsigned DATA_W_DEF  = 16;
  localparam int unsigned FIELD_W_DEF = 14;

  typedef enum logic {
    ALU_ADD = 1'b0,
    ALU_MUL = 1'b1
  } alu_op_e;
endpackage

// File: rtl/acc_reg.sv
module acc_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/acc_pc.sv
module acc_pc #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  output logic [ADDR_W-1:0] pc
);
  localparam int unsigned BYTES_PER_WORD = DATA_W / 8;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BYTES_PER_WORD);

  always_ff @(posedge clk) begin
    if (rst)       pc <= '0;
    else if (step) pc <= pc + STEP;
  end
endmodule

// File: rtl/acc_mar.sv
module acc_mar #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned FIELD_W = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_pc,
  input  logic               ld_field,
  input  logic [ADDR_W-1:0]  pc,
  input  logic [FIELD_W-1:0] field,
  output logic [ADDR_W-1:0]  mar
);
  localparam int unsigned PAD_W = ADDR_W - FIELD_W;

  logic [ADDR_W-1:0] field_ext;
  assign field_ext = {{PAD_W{1'b0}}, field};

  always_ff @(posedge clk) begin
    if (rst)           mar <= '0;
    else if (ld_pc)    mar <= pc;
    else if (ld_field) mar <= field_ext;
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_dp_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  alu_op_e           op,
  output logic [DATA_W-1:0] y
);
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] prod;

  assign sum  = a + b;
  assign prod = a * b;

  always_comb begin
    unique case (op)
      ALU_MUL: y = prod;
      default: y = sum;
    endcase
  end
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_dp_pkg::*;
#(
  parameter int unsigned ADDR_W  = ADDR_W_DEF,
  parameter int unsigned DATA_W  = DATA_W_DEF,
  parameter int unsigned FIELD_W = FIELD_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_mar_pc,
  input  logic              ld_mar_ir,
  input  logic              ld_mbr_mem,
  input  logic              ld_mbr_ac,
  input  logic              pc_step,
  input  logic              ld_ir,
  input  logic              ld_ac_mbr,
  input  logic              ld_ac_alu,
  input  logic              alu_mul,
  input  logic              wr_strobe,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_rd_req,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] ac,
  output logic [DATA_W-1:0] ir
);
  logic [DATA_W-1:0] mbr_q, mbr_d, ac_d, alu_y;
  logic              mbr_en, ac_en;
  alu_op_e           op_sel;

  assign op_sel = alu_mul ? ALU_MUL : ALU_ADD;

  acc_pc #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pc (
    .clk(clk), .rst(rst), .step(pc_step), .pc(pc)
  );

  acc_mar #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W)) u_mar (
    .clk(clk), .rst(rst), .ld_pc(ld_mar_pc), .ld_field(ld_mar_ir),
    .pc(pc), .field(ir[FIELD_W-1:0]), .mar(mem_addr)
  );

  assign mbr_en = ld_mbr_mem | ld_mbr_ac;
  assign mbr_d  = ld_mbr_mem ? mem_rdata : ac;

  acc_reg #(.W(DATA_W)) u_mbr (
    .clk(clk), .rst(rst), .en(mbr_en), .d(mbr_d), .q(mbr_q)
  );

  acc_reg #(.W(DATA_W)) u_ir (
    .clk(clk), .rst(rst), .en(ld_ir), .d(mbr_q), .q(ir)
  );

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .a(ac), .b(mbr_q), .op(op_sel), .y(alu_y)
  );

  assign ac_en = ld_ac_mbr | ld_ac_alu;
  assign ac_d  = ld_ac_mbr ? mbr_q : alu_y;

  acc_reg #(.W(DATA_W)) u_ac (
    .clk(clk), .rst(rst), .en(ac_en), .d(ac_d), .q(ac)
  );

  assign mem_wdata  = mbr_q;
  assign mem_rd_req = ld_mbr_mem;
  assign mem_wr_req = wr_strobe;
endmodule

// File: rtl/acc_datapath_chk.sv
module acc_datapath_chk #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned FIELD_W = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              ld_mar_pc,
  input logic              ld_mar_ir,
  input logic              ld_mbr_mem,
  input logic              ld_mbr_ac,
  input logic              pc_step,
  input logic              ld_ir,
  input logic              ld_ac_mbr,
  input logic              ld_ac_alu,
  input logic              alu_mul,
  input logic              wr_strobe,
  input logic [DATA_W-1:0] mem_rdata,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_rd_req,
  input logic              mem_wr_req,
  input logic [ADDR_W-1:0] pc,
  input logic [DATA_W-1:0] ac,
  input logic [DATA_W-1:0] ir
);
  localparam int unsigned PAD_W = ADDR_W - FIELD_W;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (pc == '0 && ac == '0 && ir == '0 && mem_addr == '0 && mem_wdata == '0)); // R1

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    pc_step |=> pc == $past(pc) + ADDR_W'(2)); // R2

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !pc_step |=> $stable(pc)); // R11

  AST_MAR_FROM_PC: assert property (@(posedge clk) disable iff (rst)
    ld_mar_pc |=> mem_addr == $past(pc)); // R3

  AST_MAR_FROM_FIELD: assert property (@(posedge clk) disable iff (rst)
    (ld_mar_ir && !ld_mar_pc) |=> mem_addr == {{PAD_W{1'b0}}, $past(ir[FIELD_W-1:0])}); // R4

  AST_MBR_FROM_MEM: assert property (@(posedge clk) disable iff (rst)
    ld_mbr_mem |=> mem_wdata == $past(mem_rdata)); // R5

  AST_RD_REQ: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req == ld_mbr_mem); // R5

  AST_MBR_FROM_AC: assert property (@(posedge clk) disable iff (rst)
    (ld_mbr_ac && !ld_mbr_mem) |=> mem_wdata == $past(ac)); // R6

  AST_IR_LOAD: assert property (@(posedge clk) disable iff (rst)
    ld_ir |=> ir == $past(mem_wdata)); // R7

  AST_AC_DIRECT: assert property (@(posedge clk) disable iff (rst)
    ld_ac_mbr |=> ac == $past(mem_wdata)); // R8

  AST_AC_ADD: assert property (@(posedge clk) disable iff (rst)
    (ld_ac_alu && !ld_ac_mbr && !alu_mul) |=> ac == DATA_W'($past(ac) + $past(mem_wdata))); // R9

  AST_AC_MUL: assert property (@(posedge clk) disable iff (rst)
    (ld_ac_alu && !ld_ac_mbr && alu_mul) |=> ac == DATA_W'($past(ac) * $past(mem_wdata))); // R9

  AST_WR_REQ: assert property (@(posedge clk) disable iff (rst)
    mem_wr_req == wr_strobe); // R10

  AST_AC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(ld_ac_mbr || ld_ac_alu) |=> $stable(ac)); // R11
endmodule

bind acc_datapath acc_datapath_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIELD_W(FIELD_W)
) u_chk (.*);

// File: tb/acc_datapath_bench.sv
`timescale 1ns/1ps
module acc_datapath_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_mar_pc, ld_mar_ir, ld_mbr_mem, ld_mbr_ac, pc_step;
  logic        ld_ir, ld_ac_mbr, ld_ac_alu, alu_mul, wr_strobe;
  logic [15:0] mem_rdata;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_rd_req, mem_wr_req;
  logic [31:0] pc;
  logic [15:0] ac, ir;

  logic        use_mem;
  logic [15:0] rd_val;
  logic [15:0] mem [0:127];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  acc_datapath u_acc_datapath (.*);

  assign mem_rdata = use_mem ? mem[mem_addr[7:1]] : rd_val;

  always @(posedge clk) begin
    if (mem_wr_req) mem[mem_addr[7:1]] <= mem_wdata;
  end

  task automatic clr();
    ld_mar_pc = 0; ld_mar_ir = 0; ld_mbr_mem = 0; ld_mbr_ac = 0; pc_step = 0;
    ld_ir = 0; ld_ac_mbr = 0; ld_ac_alu = 0; alu_mul = 0; wr_strobe = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    clr();
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sweep_val(input int i);
    logic [15:0] t [16] = '{16'h0000, 16'h0001, 16'h0002, 16'h0003, 16'h7FFF, 16'h8000,
                           16'hFFFF, 16'hFFFE, 16'h00FF, 16'h0100, 16'h1234, 16'hABCD,
                           16'h0007, 16'h4000, 16'hC001, 16'h0101};
    return t[i];
  endfunction

  // Set AC to a value through the buffer register
  task automatic put_ac(input logic [15:0] v);
    rd_val = v; ld_mbr_mem = 1; tick();
    ld_ac_mbr = 1; tick();
  endtask

  initial begin
    clr();
    use_mem = 0;
    rd_val  = '0;
    for (int i = 0; i < 128; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1 pc", pc, 0); chk("R1 ac", {16'h0, ac}, 0); chk("R1 ir", {16'h0, ir}, 0);
    chk("R1 mar", mem_addr, 0); chk("R1 mbr", {16'h0, mem_wdata}, 0);

    // R2: PC steps by 2
    for (int i = 1; i <= 10; i++) begin
      pc_step = 1; tick();
      chk("R2 pc step", pc, 32'(2 * i));
    end
    tick();
    chk("R2/R11 pc hold", pc, 32'd20);

    // R5: read request mirrors strobe, MBR loads read data
    rd_val = 16'hBEEF; ld_mbr_mem = 1; #1;
    chk("R5 rd_req", {31'h0, mem_rd_req}, 1);
    tick();
    chk("R5 mbr", {16'h0, mem_wdata}, 32'hBEEF);
    chk("R5 rd_req low", {31'h0, mem_rd_req}, 0);
    // R7: IR from MBR
    ld_ir = 1; tick();
    chk("R7 ir", {16'h0, ir}, 32'hBEEF);
    // R4: address field zero-extended (field = 0x3EEF)
    ld_mar_ir = 1; tick();
    chk("R4 mar field", mem_addr, 32'h0000_3EEF);
    // R3: PC has priority over the address field
    ld_mar_pc = 1; ld_mar_ir = 1; tick();
    chk("R3 mar pc prio", mem_addr, 32'd20);
    // R8: direct load
    ld_ac_mbr = 1; tick();
    chk("R8 ac direct", {16'h0, ac}, 32'hBEEF);
    // R6: MBR from AC
    rd_val = 16'h1111;
    ld_mbr_ac = 1; tick();
    chk("R6 mbr from ac", {16'h0, mem_wdata}, 32'hBEEF);
    // R5: memory wins over AC
    ld_mbr_mem = 1; ld_mbr_ac = 1; tick();
    chk("R5 mbr prio", {16'h0, mem_wdata}, 32'h1111);
    // R8: direct wins over ALU
    ld_ac_mbr = 1; ld_ac_alu = 1; alu_mul = 1; tick();
    chk("R8 ac prio", {16'h0, ac}, 32'h1111);
    // R10: write request mirrors strobe
    wr_strobe = 1; #1;
    chk("R10 wr_req", {31'h0, mem_wr_req}, 1);
    wr_strobe = 0;
    // R11: nothing changes with no strobes
    tick(); tick();
    chk("R11 ac hold", {16'h0, ac}, 32'h1111);
    chk("R11 ir hold", {16'h0, ir}, 32'hBEEF);
    chk("R11 mar hold", mem_addr, 32'd20);
    chk("R11 mbr hold", {16'h0, mem_wdata}, 32'h1111);

    // R9: arithmetic sweep over value pairs, both operations
    for (int ia = 0; ia < 16; ia++) begin
      for (int ib = 0; ib < 16; ib++) begin
        for (int op = 0; op < 2; op++) begin
          longint ea;
          put_ac(sweep_val(ia));
          rd_val = sweep_val(ib); ld_mbr_mem = 1; tick();
          ld_ac_alu = 1; alu_mul = (op == 1); tick();
          if (op == 1) ea = (longint'(sweep_val(ia)) * longint'(sweep_val(ib))) & 64'hFFFF;
          else         ea = (longint'(sweep_val(ia)) + longint'(sweep_val(ib))) & 64'hFFFF;
          chk(op == 1 ? "R9 mul" : "R9 add", {16'h0, ac}, 32'(ea));
        end
      end
    end

    // Full program through the memory model: reset, then fetch/execute
    rst = 1; tick(); rst = 0;
    chk("R1 pc after rerun reset", pc, 0);
    mem[0] = 16'h0040;            // load  0x40
    mem[1] = 16'h8042;            // add   0x42
    mem[2] = 16'hC044;            // mul   0x44
    mem[3] = 16'h4046;            // store 0x46
    mem[32] = 16'd7; mem[33] = 16'd5; mem[34] = 16'd300; mem[35] = 16'h0;
    use_mem = 1;
    for (int k = 0; k < 4; k++) begin
      ld_mar_pc = 1; tick();
      chk("R10 fetch addr", mem_addr, 32'(2 * k));
      ld_mbr_mem = 1; pc_step = 1; tick();
      ld_ir = 1; tick();
      chk("R7 fetched ir", {16'h0, ir}, {16'h0, mem[k]});
      ld_mar_ir = 1;
      if (k == 3) ld_mbr_ac = 1;
      tick();
      chk("R4 operand addr", mem_addr, {18'h0, mem[k][13:0]});
      if (k == 3) begin
        wr_strobe = 1; tick(); tick();
      end else begin
        ld_mbr_mem = 1; tick();
        if (k == 0) ld_ac_mbr = 1;
        else begin ld_ac_alu = 1; alu_mul = (k == 2); end
        tick();
      end
    end
    chk("R2 pc after program", pc, 32'd8);
    chk("R9 program ac", {16'h0, ac}, 32'd3600);
    chk("R10 stored word", {16'h0, mem[35]}, 32'd3600);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule